// File: doc/BRIEF.md
# Age-Ordered Issue Scheduler with Round-Robin Unit Selection

This block is one out-of-order scheduler buffer that holds dispatched instructions until their source operands are available and then sends them to execution pipelines. Each instruction arrives with a destination tag, a set of source tags with a pending flag for each, a resource group and a fixed execution latency. Every buffer slot is free, waiting for operands, ready, or issued and executing. Waiting slots watch two sources of tag broadcasts: an external wakeup port, and the block's own completions.

The pipelines are arranged as `GROUPS` resource groups of `UNITS` units each, and pipe number `p` belongs to group `p / UNITS`. A unit accepts a single instruction and stays occupied until that instruction writes back, so it is not pipelined. In each group, the oldest ready instruction is issued on every cycle that the group has a free unit. The free unit is chosen round-robin, starting after the unit that group used last. When an issued instruction's latency runs out, the block reports a write-back on its pipe and frees the slot. The block also reports occupancy, a full flag, peak occupancy and a histogram of the number of issues per cycle.

Top module: `ooo_issue_sched`

## Requirements
- R1: While reset is asserted and just after it, `occ`, `peak_occ`, `sched_full`, `iss_vld`, `wb_vld` and every `iss_hist` bin are zero.
- R2: An instruction dispatched with no pending source is ready after the dispatch edge and shows on `iss_vld` in the cycle after that edge, never in the cycle it is presented.
- R3: An instruction with a pending source stays waiting. A wakeup on that tag clears the pending bit at an edge, the slot becomes ready at the next edge, and the issue shows in the cycle after that second edge.
- R4: Within a group, when several slots are ready, the one dispatched earliest issues first, whatever its slot position.
- R5: Within a group, the unit chosen is the first free unit found searching upward, with wrap-around, from the unit after the one last used. After reset, unit 0 is tried first.
- R6: A unit that holds an instruction receives no new issue until the edge at which that instruction writes back has passed.
- R7: An instruction issued at edge t with latency L raises `wb_vld` on its pipe, with `wb_tag` equal to its destination tag, in the cycle after edge t+L-1. A latency of 0 behaves as 1.
- R8: The block's own write-back acts as a wakeup for waiting slots whose source tag matches the completed destination tag.
- R9: `sched_full` is high exactly when all `DEPTH` slots are occupied. A dispatch presented while it is high is dropped, and the dropped instruction never issues.
- R10: `peak_occ` holds the largest `occ` seen since reset and is updated one edge after the occupancy is reached.
- R11: At every edge, the `iss_hist` bin whose index equals the number of groups issuing in that cycle increments by one.
- R12: Groups issue independently. Each group issues at most one instruction per cycle, and two groups may issue in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_vld | input | 1 | Dispatch request |
| disp_dst | input | TAG_W | Destination tag of the dispatched instruction |
| disp_src | input | NSRC*TAG_W | Source tags |
| disp_pend | input | NSRC | Source-not-yet-available flags |
| disp_grp | input | GRP_W | Resource group |
| disp_lat | input | LAT_W | Execution latency in cycles |
| wake_vld | input | 1 | External wakeup broadcast |
| wake_tag | input | TAG_W | Tag being broadcast |
| iss_vld | output | PIPES | Issue strobe per pipe |
| iss_tag | output | PIPES*TAG_W | Destination tag issued on each pipe |
| wb_vld | output | PIPES | Write-back / ready-to-retire strobe per pipe |
| wb_tag | output | PIPES*TAG_W | Destination tag completing on each pipe |
| sched_full | output | 1 | All slots occupied |
| occ | output | OCC_W | Current occupied slot count |
| peak_occ | output | OCC_W | Highest occupancy since reset |
| iss_hist | output | (GROUPS+1)*CNT_W | Cycle counts, indexed by issues per cycle |

## Verification
Several rules are checked by assertions on every cycle. Each group issues at most one instruction per cycle. A unit that has just issued, or is writing back, is not issued to. Occupancy does not grow while the buffer is full, and grows by at most one per cycle. The peak value never falls below an earlier occupancy. The bench scenarios cover the rest: the exact cycle offsets from dispatch, wakeup and issue to write-back, oldest-first order when age and slot position disagree, the round-robin unit sequence, the dropping of a dispatch when the buffer is full, and the contents of the histogram.

// File: rtl/issq_pkg.sv
`timescale 1ns/1ps
package issq_pkg;
  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RDY  = 2'd2,
    ST_ISS  = 2'd3
  } ent_state_e;
endpackage

// File: rtl/issq_age_pick.sv
`timescale 1ns/1ps
// Age matrix: older_q[j][i] set means slot j was dispatched before slot i.
module issq_age_pick #(
  parameter int DEPTH  = 8,
  parameter int GROUPS = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [DEPTH-1:0]               live,
  input  logic [DEPTH-1:0]               alloc_oh,
  input  logic [GROUPS-1:0][DEPTH-1:0]   req,
  output logic [GROUPS-1:0][DEPTH-1:0]   gnt
);
  logic [DEPTH-1:0][DEPTH-1:0] older_q, older_d;
  logic                        age_en;

  assign age_en = |alloc_oh;

  always_comb begin
    older_d = older_q;
    for (int i = 0; i < DEPTH; i++) begin
      for (int j = 0; j < DEPTH; j++) begin
        if (alloc_oh[j]) older_d[i][j] = live[i];
        if (alloc_oh[i]) older_d[i][j] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      older_q <= '0;
    else if (age_en) older_q <= older_d;
  end

  always_comb begin
    gnt = '0;
    for (int g = 0; g < GROUPS; g++) begin
      for (int i = 0; i < DEPTH; i++) begin
        logic blocked;
        blocked = 1'b0;
        for (int j = 0; j < DEPTH; j++) begin
          if (req[g][j] && older_q[j][i]) blocked = 1'b1;
        end
        gnt[g][i] = req[g][i] && !blocked;
      end
    end
  end
endmodule

// File: rtl/issq_unit_rr.sv
`timescale 1ns/1ps
// Round-robin choice of a free unit inside one resource group.
module issq_unit_rr #(
  parameter int UNITS  = 2,
  parameter int UNIT_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [UNITS-1:0]  busy,
  input  logic              take,
  output logic [UNIT_W-1:0] pick,
  output logic              any_free
);
  logic [UNIT_W-1:0] last_q, last_d;

  always_comb begin
    pick     = '0;
    any_free = 1'b0;
    for (int k = 1; k <= UNITS; k++) begin
      int c;
      c = (int'(last_q) + k) % UNITS;
      if (!any_free && !busy[c]) begin
        any_free = 1'b1;
        pick     = UNIT_W'(c);
      end
    end
  end

  always_comb begin
    last_d = last_q;
    if (take) last_d = pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_q <= UNIT_W'(UNITS - 1);
    else if (take) last_q <= last_d;
  end
endmodule

// File: rtl/issq_stats.sv
`timescale 1ns/1ps
// Occupancy, peak occupancy and issues-per-cycle histogram.
module issq_stats #(
  parameter int DEPTH  = 8,
  parameter int GROUPS = 2,
  parameter int CNT_W  = 16,
  parameter int OCC_W  = 4,
  parameter int ISS_W  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DEPTH-1:0]          live,
  input  logic [ISS_W-1:0]          n_iss,
  output logic [OCC_W-1:0]          occ,
  output logic                      full,
  output logic [OCC_W-1:0]          peak,
  output logic [GROUPS:0][CNT_W-1:0] hist
);
  logic [OCC_W-1:0]           peak_q, peak_d;
  logic [GROUPS:0][CNT_W-1:0] hist_q, hist_d;

  assign occ  = OCC_W'($countones(live));
  assign full = (occ == OCC_W'(DEPTH));

  always_comb begin
    peak_d = (occ > peak_q) ? occ : peak_q;
    hist_d = hist_q;
    for (int b = 0; b <= GROUPS; b++) begin
      if (n_iss == ISS_W'(b)) hist_d[b] = hist_q[b] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peak_q <= '0;
      hist_q <= '0;
    end else begin
      peak_q <= peak_d;
      hist_q <= hist_d;
    end
  end

  assign peak = peak_q;
  assign hist = hist_q;
endmodule

// File: rtl/ooo_issue_sched.sv
`timescale 1ns/1ps
module ooo_issue_sched
  import issq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int GROUPS = 2,
  parameter int UNITS  = 2,
  parameter int TAG_W  = 4,
  parameter int LAT_W  = 3,
  parameter int NSRC   = 2,
  parameter int CNT_W  = 16,
  localparam int PIPES  = GROUPS * UNITS,
  localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int OCC_W  = $clog2(DEPTH + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           disp_vld,
  input  logic [TAG_W-1:0]               disp_dst,
  input  logic [NSRC-1:0][TAG_W-1:0]     disp_src,
  input  logic [NSRC-1:0]                disp_pend,
  input  logic [GRP_W-1:0]               disp_grp,
  input  logic [LAT_W-1:0]               disp_lat,
  input  logic                           wake_vld,
  input  logic [TAG_W-1:0]               wake_tag,
  output logic [PIPES-1:0]               iss_vld,
  output logic [PIPES-1:0][TAG_W-1:0]    iss_tag,
  output logic [PIPES-1:0]               wb_vld,
  output logic [PIPES-1:0][TAG_W-1:0]    wb_tag,
  output logic                           sched_full,
  output logic [OCC_W-1:0]               occ,
  output logic [OCC_W-1:0]               peak_occ,
  output logic [GROUPS:0][CNT_W-1:0]     iss_hist
);
  localparam int UNIT_W = (UNITS > 1) ? $clog2(UNITS) : 1;
  localparam int PIPE_W = (PIPES > 1) ? $clog2(PIPES) : 1;
  localparam int ISS_W  = $clog2(GROUPS + 1);

  // per-slot state
  ent_state_e                 st_q   [DEPTH];
  ent_state_e                 st_d   [DEPTH];
  logic [NSRC-1:0]            pend_q [DEPTH];
  logic [NSRC-1:0]            pend_d [DEPTH];
  logic [NSRC-1:0][TAG_W-1:0] src_q  [DEPTH];
  logic [NSRC-1:0][TAG_W-1:0] src_d  [DEPTH];
  logic [TAG_W-1:0]           dst_q  [DEPTH];
  logic [TAG_W-1:0]           dst_d  [DEPTH];
  logic [GRP_W-1:0]           grp_q  [DEPTH];
  logic [GRP_W-1:0]           grp_d  [DEPTH];
  logic [LAT_W-1:0]           lat_q  [DEPTH];
  logic [LAT_W-1:0]           lat_d  [DEPTH];
  logic [LAT_W-1:0]           cnt_q  [DEPTH];
  logic [LAT_W-1:0]           cnt_d  [DEPTH];
  logic [PIPE_W-1:0]          unit_q [DEPTH];
  logic [PIPE_W-1:0]          unit_d [DEPTH];

  logic [DEPTH-1:0]           live, done_e, alloc_oh, issued_e;
  logic [PIPE_W-1:0]          tgt_pipe [DEPTH];
  logic [DEPTH-1:0][NSRC-1:0] hit;
  logic [NSRC-1:0]            disp_hit;
  logic                       alloc_ok;
  logic [PIPES-1:0]           busy_p;
  logic [GROUPS-1:0][DEPTH-1:0] req, gnt;
  logic [GROUPS-1:0][UNIT_W-1:0] pick_u;
  logic [GROUPS-1:0]          free_g, iss_go;
  logic [GROUPS-1:0][TAG_W-1:0] iss_dst;
  logic [ISS_W-1:0]           n_iss;

  // slot status decode
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      live[i]   = (st_q[i] != ST_FREE);
      done_e[i] = (st_q[i] == ST_ISS) && (cnt_q[i] == LAT_W'(1));
    end
  end

  // per-pipe busy and write-back reporting
  always_comb begin
    busy_p = '0;
    wb_vld = '0;
    wb_tag = '0;
    for (int p = 0; p < PIPES; p++) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (st_q[i] == ST_ISS && unit_q[i] == PIPE_W'(p)) begin
          busy_p[p] = 1'b1;
          if (done_e[i]) begin
            wb_vld[p] = 1'b1;
            wb_tag[p] = dst_q[i];
          end
        end
      end
    end
  end

  // tag match against external and internal broadcasts
  always_comb begin
    hit      = '0;
    disp_hit = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (wake_vld && wake_tag == disp_src[s]) disp_hit[s] = 1'b1;
      for (int p = 0; p < PIPES; p++) begin
        if (wb_vld[p] && wb_tag[p] == disp_src[s]) disp_hit[s] = 1'b1;
      end
      for (int i = 0; i < DEPTH; i++) begin
        if (wake_vld && wake_tag == src_q[i][s]) hit[i][s] = 1'b1;
        for (int p = 0; p < PIPES; p++) begin
          if (wb_vld[p] && wb_tag[p] == src_q[i][s]) hit[i][s] = 1'b1;
        end
      end
    end
  end

  // lowest free slot takes the dispatch
  always_comb begin
    alloc_oh = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!live[i]) alloc_oh = DEPTH'(1) << i;
    end
    alloc_ok = disp_vld && !sched_full;
    if (!alloc_ok) alloc_oh = '0;
  end

  // ready requests per group
  always_comb begin
    req = '0;
    for (int g = 0; g < GROUPS; g++) begin
      for (int i = 0; i < DEPTH; i++) begin
        req[g][i] = (st_q[i] == ST_RDY) && (grp_q[i] == GRP_W'(g));
      end
    end
  end

  issq_age_pick #(.DEPTH(DEPTH), .GROUPS(GROUPS)) u_age (
    .clk      (clk),
    .rst_n    (rst_n),
    .live     (live),
    .alloc_oh (alloc_oh),
    .req      (req),
    .gnt      (gnt)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign iss_go[g] = (|gnt[g]) && free_g[g];
    issq_unit_rr #(.UNITS(UNITS), .UNIT_W(UNIT_W)) u_rr (
      .clk      (clk),
      .rst_n    (rst_n),
      .busy     (busy_p[g*UNITS +: UNITS]),
      .take     (iss_go[g]),
      .pick     (pick_u[g]),
      .any_free (free_g[g])
    );
  end

  // issue outputs and per-slot issue decision
  always_comb begin
    iss_dst  = '0;
    issued_e = '0;
    for (int i = 0; i < DEPTH; i++) tgt_pipe[i] = '0;
    for (int g = 0; g < GROUPS; g++) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (gnt[g][i]) iss_dst[g] = dst_q[i];
        if (gnt[g][i] && iss_go[g]) begin
          issued_e[i] = 1'b1;
          tgt_pipe[i] = PIPE_W'(g * UNITS + int'(pick_u[g]));
        end
      end
    end
    iss_vld = '0;
    iss_tag = '0;
    for (int g = 0; g < GROUPS; g++) begin
      for (int u = 0; u < UNITS; u++) begin
        if (iss_go[g] && pick_u[g] == UNIT_W'(u)) begin
          iss_vld[g*UNITS + u] = 1'b1;
          iss_tag[g*UNITS + u] = iss_dst[g];
        end
      end
    end
    n_iss = ISS_W'($countones(iss_go));
  end

  // slot next state
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      st_d[i]   = st_q[i];
      pend_d[i] = pend_q[i];
      src_d[i]  = src_q[i];
      dst_d[i]  = dst_q[i];
      grp_d[i]  = grp_q[i];
      lat_d[i]  = lat_q[i];
      cnt_d[i]  = cnt_q[i];
      unit_d[i] = unit_q[i];
      unique case (st_q[i])
        ST_FREE: begin
          if (alloc_oh[i]) begin
            src_d[i]  = disp_src;
            dst_d[i]  = disp_dst;
            grp_d[i]  = disp_grp;
            lat_d[i]  = (disp_lat == '0) ? LAT_W'(1) : disp_lat;
            pend_d[i] = disp_pend & ~disp_hit;
            st_d[i]   = (disp_pend == '0) ? ST_RDY : ST_WAIT;
          end
        end
        ST_WAIT: begin
          pend_d[i] = pend_q[i] & ~hit[i];
          if (pend_q[i] == '0) st_d[i] = ST_RDY;
        end
        ST_RDY: begin
          if (issued_e[i]) begin
            st_d[i]   = ST_ISS;
            cnt_d[i]  = lat_q[i];
            unit_d[i] = tgt_pipe[i];
          end
        end
        ST_ISS: begin
          if (done_e[i]) st_d[i] = ST_FREE;
          else           cnt_d[i] = cnt_q[i] - 1'b1;
        end
        default: st_d[i] = ST_FREE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        st_q[i]   <= ST_FREE;
        pend_q[i] <= '0;
        src_q[i]  <= '0;
        dst_q[i]  <= '0;
        grp_q[i]  <= '0;
        lat_q[i]  <= '0;
        cnt_q[i]  <= '0;
        unit_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        st_q[i]   <= st_d[i];
        pend_q[i] <= pend_d[i];
        cnt_q[i]  <= cnt_d[i];
        unit_q[i] <= unit_d[i];
        if (alloc_oh[i]) begin
          src_q[i] <= src_d[i];
          dst_q[i] <= dst_d[i];
          grp_q[i] <= grp_d[i];
          lat_q[i] <= lat_d[i];
        end
      end
    end
  end

  issq_stats #(
    .DEPTH(DEPTH), .GROUPS(GROUPS), .CNT_W(CNT_W), .OCC_W(OCC_W), .ISS_W(ISS_W)
  ) u_stats (
    .clk   (clk),
    .rst_n (rst_n),
    .live  (live),
    .n_iss (n_iss),
    .occ   (occ),
    .full  (sched_full),
    .peak  (peak_occ),
    .hist  (iss_hist)
  );
endmodule

// File: rtl/issq_chk.sv
`timescale 1ns/1ps
module issq_chk #(
  parameter int DEPTH  = 8,
  parameter int UNITS  = 2,
  parameter int PIPES  = 4,
  parameter int OCC_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PIPES-1:0] iss_vld,
  input logic [PIPES-1:0] wb_vld,
  input logic             sched_full,
  input logic [OCC_W-1:0] occ,
  input logic [OCC_W-1:0] peak_occ
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  for (genvar g = 0; g < PIPES / UNITS; g++) begin : g_grp
    assert_one_per_group_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(iss_vld[g*UNITS +: UNITS]));
  end

  for (genvar p = 0; p < PIPES; p++) begin : g_pipe
    assert_unit_held_after_issue_R6: assert property (@(posedge clk) disable iff (!rst_n)
      iss_vld[p] |=> !iss_vld[p]);
    assert_no_issue_during_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wb_vld[p] |-> !iss_vld[p]);
  end

  assert_peak_covers_occ_R10: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (peak_occ >= $past(occ)) && (peak_occ >= $past(peak_occ)));

  assert_no_growth_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(sched_full)) |-> (occ <= $past(occ)));

  assert_occ_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ({1'b0, occ} <= {1'b0, $past(occ)} + 1'b1));
endmodule

bind ooo_issue_sched issq_chk #(
  .DEPTH(DEPTH), .UNITS(UNITS), .PIPES(PIPES), .OCC_W(OCC_W)
) u_issq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .iss_vld    (iss_vld),
  .wb_vld     (wb_vld),
  .sched_full (sched_full),
  .occ        (occ),
  .peak_occ   (peak_occ)
);

// File: tb/ooo_issue_sched_bench.sv
`timescale 1ns/1ps
module ooo_issue_sched_bench;
  localparam int DEPTH = 8, GROUPS = 2, UNITS = 2, TAG_W = 4, LAT_W = 3, NSRC = 2, CNT_W = 16;
  localparam int PIPES = GROUPS * UNITS, OCC_W = 4;
  localparam int TOTAL_ISSUES = 24;

  logic clk, rst_n;
  logic disp_vld;
  logic [TAG_W-1:0] disp_dst;
  logic [NSRC-1:0][TAG_W-1:0] disp_src;
  logic [NSRC-1:0] disp_pend;
  logic [0:0] disp_grp;
  logic [LAT_W-1:0] disp_lat;
  logic wake_vld;
  logic [TAG_W-1:0] wake_tag;
  logic [PIPES-1:0] iss_vld, wb_vld;
  logic [PIPES-1:0][TAG_W-1:0] iss_tag, wb_tag;
  logic sched_full;
  logic [OCC_W-1:0] occ, peak_occ;
  logic [GROUPS:0][CNT_W-1:0] iss_hist;

  int checks, errors, ncyc;
  int rr_last [GROUPS];

  ooo_issue_sched u_ooo_issue_sched (
    .clk(clk), .rst_n(rst_n), .disp_vld(disp_vld), .disp_dst(disp_dst),
    .disp_src(disp_src), .disp_pend(disp_pend), .disp_grp(disp_grp),
    .disp_lat(disp_lat), .wake_vld(wake_vld), .wake_tag(wake_tag),
    .iss_vld(iss_vld), .iss_tag(iss_tag), .wb_vld(wb_vld), .wb_tag(wb_tag),
    .sched_full(sched_full), .occ(occ), .peak_occ(peak_occ), .iss_hist(iss_hist)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) if (rst_n) ncyc <= ncyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    disp_vld  = 1'b0;
    disp_pend = '0;
    wake_vld  = 1'b0;
  endtask

  task automatic put_disp(input int dst, input int grp, input int lat, input bit pend, input int stag);
    disp_vld    = 1'b1;
    disp_dst    = TAG_W'(dst);
    disp_grp    = 1'(grp);
    disp_lat    = LAT_W'(lat);
    disp_pend   = {1'b0, pend};
    disp_src[0] = TAG_W'(stag);
    disp_src[1] = '0;
  endtask

  task automatic put_wake(input int tag);
    wake_vld = 1'b1;
    wake_tag = TAG_W'(tag);
  endtask

  function automatic int next_pipe(input int g);
    return g * UNITS + ((rr_last[g] + 1) % UNITS);
  endfunction

  // single issue expected on the next round-robin pipe of group g
  task automatic exp_iss(input int g, input int tag, input string req);
    int p;
    p = next_pipe(g);
    chk(iss_vld == PIPES'(1 << p), req, int'(iss_vld), 1 << p);
    chk(int'(iss_tag[p]) == tag, req, int'(iss_tag[p]), tag);
    rr_last[g] = p % UNITS;
  endtask

  task automatic exp_wb(input int p, input int tag, input string req);
    chk(wb_vld == PIPES'(1 << p), req, int'(wb_vld), 1 << p);
    chk(int'(wb_tag[p]) == tag, req, int'(wb_tag[p]), tag);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int pa, pb, pc;
    int seen;
    bit ghost;
    checks = 0; errors = 0; ncyc = 0;
    rr_last[0] = UNITS - 1; rr_last[1] = UNITS - 1;
    rst_n = 1'b0; disp_vld = 1'b0; disp_dst = '0; disp_src = '0; disp_pend = '0;
    disp_grp = '0; disp_lat = '0; wake_vld = 1'b0; wake_tag = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(occ == 0 && peak_occ == 0 && !sched_full, "R1 occ/peak/full", int'(occ) + int'(peak_occ), 0);
    chk(iss_vld == 0 && wb_vld == 0, "R1 strobes", int'(iss_vld) + int'(wb_vld), 0);
    chk(iss_hist == '0, "R1 hist", int'(iss_hist[0]), 0);
    rst_n = 1'b1;
    #1;

    // Scenario A: R2 and R7, latency 3
    put_disp(5, 0, 3, 0, 0);
    #1;
    chk(iss_vld == 0, "R2 no same-cycle issue", int'(iss_vld), 0);
    step();
    pa = next_pipe(0);
    exp_iss(0, 5, "R2 issue after dispatch edge");
    chk(occ == 1, "R9 occ one", int'(occ), 1);
    step();
    chk(iss_vld == 0 && wb_vld == 0, "R7 no early wb", int'(wb_vld), 0);
    step();
    chk(wb_vld == 0, "R7 no early wb 2", int'(wb_vld), 0);
    step();
    exp_wb(pa, 5, "R7 wb at L");
    step();
    chk(wb_vld == 0 && occ == 0, "R7 slot freed", int'(occ), 0);
    chk(peak_occ == 1, "R10 peak one", int'(peak_occ), 1);

    // Scenario A2: R6 unit held until write-back
    put_disp(1, 0, 2, 0, 0);
    step();
    pa = next_pipe(0);
    exp_iss(0, 1, "R6 first issue");
    put_disp(2, 0, 2, 0, 0);
    step();
    pb = next_pipe(0);
    exp_iss(0, 2, "R6 second unit");
    put_disp(3, 0, 2, 0, 0);
    step();
    chk(iss_vld == 0, "R6 both units held", int'(iss_vld), 0);
    exp_wb(pa, 1, "R7 first wb");
    step();
    exp_wb(pb, 2, "R7 second wb");
    chk(next_pipe(0) == pa, "R5 rr returns to freed unit", next_pipe(0), pa);
    exp_iss(0, 3, "R6 issue after free");
    step();
    step();
    exp_wb(pa, 3, "R7 third wb");
    step();

    // Scenario B: R5 round-robin over free units in group 1
    for (int k = 0; k < 4; k++) begin
      put_disp(8 + k, 1, 1, 0, 0);
      step();
      chk(next_pipe(1) == 2 + (k % 2), "R5 rr sequence", next_pipe(1), 2 + (k % 2));
      exp_iss(1, 8 + k, "R5 rr issue");
      step();
      step();
    end

    // Scenario C: R3 wakeup timing and R4 age over slot order
    put_disp(3, 0, 1, 1, 15);
    step();
    put_disp(1, 0, 1, 1, 9);
    step();
    chk(iss_vld == 0, "R3 waiting not issued", int'(iss_vld), 0);
    put_wake(15);
    step();
    chk(iss_vld == 0, "R3 no issue at clear edge", int'(iss_vld), 0);
    step();
    exp_iss(0, 3, "R3 issue two edges after wake");
    step();
    step();
    put_disp(2, 0, 1, 1, 9);
    step();
    put_wake(9);
    step();
    chk(iss_vld == 0, "R3 pending cleared only", int'(iss_vld), 0);
    step();
    exp_iss(0, 1, "R4 older issues first");
    step();
    exp_iss(0, 2, "R4 younger next");
    step();
    step();

    // Scenario D: R8 own write-back wakes dependent
    put_disp(7, 1, 2, 0, 0);
    step();
    pa = next_pipe(1);
    exp_iss(1, 7, "R8 producer issue");
    put_disp(4, 1, 1, 1, 7);
    step();
    step();
    exp_wb(pa, 7, "R8 producer wb");
    step();
    chk(iss_vld == 0, "R8 not yet ready", int'(iss_vld), 0);
    step();
    exp_iss(1, 4, "R8 dependent issues");
    step();
    step();

    // Scenario F: R7 latency zero acts as one
    put_disp(6, 1, 0, 0, 0);
    step();
    pa = next_pipe(1);
    exp_iss(1, 6, "R7 lat0 issue");
    step();
    exp_wb(pa, 6, "R7 lat0 wb next cycle");
    step();

    // Scenario E: R9 full, dropped dispatch; R4 order; R10 peak
    for (int k = 0; k < DEPTH; k++) begin
      put_disp(k, 0, 1, 1, 12);
      step();
    end
    chk(sched_full && occ == DEPTH, "R9 full at depth", int'(occ), DEPTH);
    put_disp(13, 0, 1, 0, 0);
    step();
    chk(occ == DEPTH, "R9 dropped dispatch", int'(occ), DEPTH);
    chk(peak_occ == DEPTH, "R10 peak depth", int'(peak_occ), DEPTH);
    put_wake(12);
    step();
    step();
    seen = 0;
    ghost = 1'b0;
    for (int c = 0; c < 14; c++) begin
      for (int p = 0; p < PIPES; p++) begin
        if (iss_vld[p]) begin
          if (iss_tag[p] == 13) ghost = 1'b1;
          else begin
            chk(int'(iss_tag[p]) == seen, "R4 drain order", int'(iss_tag[p]), seen);
            chk(p == next_pipe(0), "R5 drain pipe", p, next_pipe(0));
            rr_last[0] = p % UNITS;
            seen++;
          end
        end
      end
      step();
    end
    chk(seen == DEPTH, "R9 all drained", seen, DEPTH);
    chk(!ghost, "R9 dropped never issues", int'(ghost), 0);
    chk(!sched_full && occ == 0, "R9 empty after drain", int'(occ), 0);
    chk(peak_occ == DEPTH, "R10 peak held", int'(peak_occ), DEPTH);

    // Scenario G: R12 both groups issue in one cycle
    put_disp(10, 0, 1, 1, 11);
    step();
    put_disp(14, 1, 1, 1, 11);
    step();
    put_wake(11);
    step();
    step();
    pa = next_pipe(0);
    pb = next_pipe(1);
    chk(iss_vld == PIPES'((1 << pa) | (1 << pb)), "R12 dual issue", int'(iss_vld), (1 << pa) | (1 << pb));
    chk(iss_tag[pa] == 10 && iss_tag[pb] == 14, "R12 dual tags", int'(iss_tag[pb]), 14);
    rr_last[0] = pa % UNITS;
    rr_last[1] = pb % UNITS;
    step();
    step();
    step();

    // R11 histogram
    pc = int'(iss_hist[0]) + int'(iss_hist[1]) + int'(iss_hist[2]);
    chk(pc == ncyc, "R11 bins sum to cycles", pc, ncyc);
    pc = int'(iss_hist[1]) + 2 * int'(iss_hist[2]);
    chk(pc == TOTAL_ISSUES, "R11 weighted sum", pc, TOTAL_ISSUES);
    chk(iss_hist[2] == 1, "R11 dual-issue bin", int'(iss_hist[2]), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule